// File: doc/BRIEF.md
# USB Control Request Auto-Responder

This block lives inside a USB device controller, beside the control endpoint. It watches the standard SETUP requests that an upstream decoder has already parsed and keeps track of the device state. The three states are Default, Address and Configured.

For the two requests that move the device between states, SET_ADDRESS and SET_CONFIGURATION, the block can close the status stage in hardware. It asks the endpoint logic to send a zero-length packet and does not interrupt firmware. It does this only when the request and the current state form a pair that actually changes the state. Every other SET_ADDRESS or SET_CONFIGURATION raises a control-stage interrupt flag so that firmware handles it.

The device state and the device address change only when the status-stage packet has been acknowledged. At that moment a device-state interrupt flag can also be raised. Each kind of request has its own enable for that flag, and the flag is raised whether or not the auto-response was used.

All request, status and acknowledge inputs are single-cycle strobes. The block never stalls them, so there is no valid/ready pairing and no back-pressure at any edge. The endpoint logic must be ready to act on a one-cycle `zlp_req` pulse. Firmware reaches the block through a plain register write port with combinational read-back. It has three 16-bit registers:

| Offset | Bit 0 | Bit 1 | Other bits |
|---|---|---|---|
| 0x2C, auto-enable register | auto-response for SET_ADDRESS | auto-response for SET_CONFIGURATION | reserved |
| 0x2E, state-change enable register | flag on an address change | flag on a configuration change | reserved |
| 0x30, flag register | control-stage flag | device-state flag | reserved |

Top module: `usb_ctl_autoresp`

## Requirements
- R1: After hardware reset, the following are all zero: every register, both interrupt flags, `zlp_req` and `dev_addr`. `dev_state` reads Default. The `dev_state` encoding is Default=0, Address=1, Configured=2.
- R2: Bits 1:0 of the auto-enable register (0x2C) and of the state-change enable register (0x2E) are writable. Bits 15:2 of both are reserved, ignore writes and read as 0. For example, writing 0xFFFF reads back 0x0003.
- R3: The request code for SET_ADDRESS is 5. When bit 0 of 0x2C is 1, a SET_ADDRESS that arrives in Default is answered by a one-cycle `zlp_req` pulse in the cycle after the status strobe, and `ctrl_irq` stays clear.
- R4: The request code for SET_CONFIGURATION is 9, and the configuration value is `req_value`. When bit 1 of 0x2C is 1, two cases are auto-answered in the same way as in R3: a nonzero value received in Address, and a zero value received in Configured. No other SET_CONFIGURATION is auto-answered.
- R5: A SET_ADDRESS or SET_CONFIGURATION that is not auto-answered does not produce `zlp_req`. Instead it sets `ctrl_irq` in the cycle after its status strobe. This covers a non-qualifying pair and a disabled enable bit.
- R6: The state changes in the cycle after `zlp_ack` of a pending request, in these cases only:
  - Default to Address on SET_ADDRESS with a nonzero address (bits 6:0).
  - Address to Configured on a nonzero configuration value.
  - Configured to Address on a zero configuration value.
- R7: The address in bits 6:0 of `req_value` is latched when the request arrives. It appears on `dev_addr` only after `zlp_ack`.
- R8: When a state change of R6 happens, `dev_irq` is set in the same cycle if the matching bit of 0x2E is 1. Bit 0 covers SET_ADDRESS and bit 1 covers SET_CONFIGURATION. This holds regardless of the bits in 0x2C.
- R9: The flags are visible at 0x30 as bit 0 = `ctrl_irq` and bit 1 = `dev_irq`. A flag stays set until a write of 1 to its bit clears it, and a write of 0 has no effect. When a flag is set and cleared in the same cycle, the set wins.
- R10: A `bus_reset` pulse returns the state to Default, clears `dev_addr` and drops any pending request. It leaves 0x2C and 0x2E unchanged.
- R11: Any other request code does not produce `zlp_req`, does not set a flag and does not change the state. Such a request also replaces any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_reset | input | 1 | USB bus reset pulse |
| req_valid | input | 1 | Decoded SETUP request strobe |
| req_code | input | 8 | Standard request code |
| req_value | input | 8 | Low byte of the request value field |
| status_stb | input | 1 | Status stage has started |
| zlp_ack | input | 1 | Status-stage packet acknowledged |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset for write and read-back |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read-back of the register at `cfg_addr` |
| zlp_req | output | 1 | One-cycle request to send a zero-length packet |
| ctrl_irq | output | 1 | Control-stage interrupt flag |
| dev_irq | output | 1 | Device-state interrupt flag |
| dev_state | output | 2 | Current device state |
| dev_addr | output | 7 | Current device address |

## Verification
The bench sweeps every combination of the following:
- device state
- request kind (SET_ADDRESS, SET_CONFIGURATION, other)
- zero or nonzero value
- auto-enable bits
- state-change enable bits

Several kinds of design error would show up in this sweep:
- A design that qualifies on the request alone would auto-answer a SET_CONFIGURATION of zero in Address.
- A design that tied the device-state flag to auto-response would lose that flag when firmware answers.
- A design that applied the address at request time would show the new address before the acknowledge.

Directed cases cover three more points. Reserved register bits must stay zero. A same-cycle set and clear of a flag must leave the flag set. A bus reset must keep the enable bits while the state returns to Default.

// File: rtl/usb_ar_pkg.sv
package usb_ar_pkg;

  typedef enum logic [1:0] {
    DS_DEFAULT    = 2'd0,
    DS_ADDRESS    = 2'd1,
    DS_CONFIGURED = 2'd2
  } dev_state_e;

  typedef enum logic [1:0] {
    RK_NONE     = 2'd0,
    RK_SET_ADDR = 2'd1,
    RK_SET_CFG  = 2'd2
  } req_kind_e;

  localparam logic [7:0] BREQ_SET_ADDRESS       = 8'd5;
  localparam logic [7:0] BREQ_SET_CONFIGURATION = 8'd9;

  // request waiting for its status stage to finish
  typedef struct packed {
    req_kind_e  kind;
    logic       autoresp;
    logic [7:0] value;
  } pend_t;

endpackage

// File: rtl/usb_ar_regs.sv
module usb_ar_regs #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_OFS = 'h2C,
  parameter logic [AW-1:0] SCE_OFS  = 'h2E,
  parameter logic [AW-1:0] FLAG_OFS = 'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ctrl_set,
  input  logic          dev_set,
  output logic [DW-1:0] rdata,
  output logic          en_addr,
  output logic          en_cfg,
  output logic          sce_addr,
  output logic          sce_cfg,
  output logic          ctrl_irq,
  output logic          dev_irq
);

  localparam logic [DW-1:0] LIVE_MASK = DW'(3);

  logic [DW-1:0] ctrl_q, sce_q, flag_q;
  logic [DW-1:0] set_vec, clr_vec;
  logic hit_ctrl, hit_sce, hit_flag;

  assign hit_ctrl = wr_en && (addr == CTRL_OFS);
  assign hit_sce  = wr_en && (addr == SCE_OFS);
  assign hit_flag = wr_en && (addr == FLAG_OFS);

  assign set_vec = {{(DW-2){1'b0}}, dev_set, ctrl_set};
  assign clr_vec = hit_flag ? (wdata & LIVE_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sce_q  <= '0;
      flag_q <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wdata & LIVE_MASK;
      if (hit_sce)  sce_q  <= wdata & LIVE_MASK;
      flag_q <= (flag_q & ~clr_vec) | set_vec;  // set wins over clear
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS)      rdata = ctrl_q;
    else if (addr == SCE_OFS)  rdata = sce_q;
    else if (addr == FLAG_OFS) rdata = flag_q;
  end

  assign en_addr  = ctrl_q[0];
  assign en_cfg   = ctrl_q[1];
  assign sce_addr = sce_q[0];
  assign sce_cfg  = sce_q[1];
  assign ctrl_irq = flag_q[0];
  assign dev_irq  = flag_q[1];

  // R9: a flag only drops after a write-one to its bit
  a_r9_ctrl_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(hit_flag && wdata[0]));
  a_r9_dev_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(hit_flag && wdata[1]));

endmodule

// File: rtl/usb_ar_decide.sv
module usb_ar_decide
  import usb_ar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       req_valid,
  input  logic [7:0] req_code,
  input  logic [7:0] req_value,
  input  dev_state_e state,
  input  logic       en_addr,
  input  logic       en_cfg,
  input  logic       status_stb,
  input  logic       zlp_ack,
  output pend_t      pend,
  output logic       zlp_req,
  output logic       ctrl_set
);

  req_kind_e kind;
  logic      qual, armed;
  pend_t     pend_q;
  logic      zlp_q;
  logic      live;

  always_comb begin
    kind = RK_NONE;
    if (req_code == BREQ_SET_ADDRESS)            kind = RK_SET_ADDR;
    else if (req_code == BREQ_SET_CONFIGURATION) kind = RK_SET_CFG;
    qual  = 1'b0;
    armed = 1'b0;
    case (kind)
      RK_SET_ADDR: begin
        qual  = (state == DS_DEFAULT);
        armed = en_addr;
      end
      RK_SET_CFG: begin
        qual  = ((state == DS_ADDRESS)    && (req_value != 8'd0)) ||
                ((state == DS_CONFIGURED) && (req_value == 8'd0));
        armed = en_cfg;
      end
      default: ;
    endcase
  end

  assign live     = (pend_q.kind != RK_NONE);
  assign ctrl_set = status_stb && live && !pend_q.autoresp && !bus_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      zlp_q  <= 1'b0;
    end else begin
      zlp_q <= status_stb && live && pend_q.autoresp && !bus_reset;
      if (bus_reset)
        pend_q <= '0;
      else if (req_valid) begin
        pend_q.kind     <= kind;
        pend_q.autoresp <= qual && armed;
        pend_q.value    <= req_value;
      end else if (zlp_ack && live)
        pend_q <= '0;
    end
  end

  assign pend    = pend_q;
  assign zlp_req = zlp_q;

  // R3: a zero-length packet request only follows an auto-armed pending request
  a_r3_zlp_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_q |-> $past(pend_q.autoresp && (pend_q.kind != RK_NONE)));

endmodule

// File: rtl/usb_ar_state.sv
module usb_ar_state
  import usb_ar_pkg::*;
#(
  parameter int DEV_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  pend_t             pend,
  input  logic              zlp_ack,
  input  logic              sce_addr,
  input  logic              sce_cfg,
  output dev_state_e        state,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              dev_set
);

  dev_state_e        state_q, state_d;
  logic [DEV_AW-1:0] addr_q, addr_d;
  logic              chg, chg_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    chg     = 1'b0;
    chg_en  = 1'b0;
    if (zlp_ack) begin
      case (pend.kind)
        RK_SET_ADDR: begin
          chg_en = sce_addr;
          if ((state_q == DS_DEFAULT) && (pend.value[DEV_AW-1:0] != '0)) begin
            state_d = DS_ADDRESS;
            addr_d  = pend.value[DEV_AW-1:0];
            chg     = 1'b1;
          end
        end
        RK_SET_CFG: begin
          chg_en = sce_cfg;
          if ((state_q == DS_ADDRESS) && (pend.value != 8'd0)) begin
            state_d = DS_CONFIGURED;
            chg     = 1'b1;
          end else if ((state_q == DS_CONFIGURED) && (pend.value == 8'd0)) begin
            state_d = DS_ADDRESS;
            chg     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dev_set = chg && chg_en && !bus_reset;

  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      state_q <= DS_DEFAULT;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign state    = state_q;
  assign dev_addr = addr_q;

  // R6: Configured is never reached straight from Default
  a_r6_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_CONFIGURED) |-> ($past(state_q) != DS_DEFAULT));
  // R7: the address only moves after an acknowledge or a bus reset
  a_r7_addr_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> ($past(zlp_ack) || $past(bus_reset)));
  // R10: bus reset lands in Default
  a_r10_bus_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (state_q == DS_DEFAULT));

endmodule

// File: rtl/usb_ctl_autoresp.sv
module usb_ctl_autoresp
  import usb_ar_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int DEV_AW = 7,
  parameter logic [AW-1:0] CTRL_OFS = 'h2C,
  parameter logic [AW-1:0] SCE_OFS  = 'h2E,
  parameter logic [AW-1:0] FLAG_OFS = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [7:0]        req_code,
  input  logic [7:0]        req_value,
  input  logic              status_stb,
  input  logic              zlp_ack,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              zlp_req,
  output logic              ctrl_irq,
  output logic              dev_irq,
  output logic [1:0]        dev_state,
  output logic [DEV_AW-1:0] dev_addr
);

  logic       en_addr, en_cfg, sce_addr, sce_cfg;
  logic       ctrl_set, dev_set;
  pend_t      pend;
  dev_state_e state;

  usb_ar_regs #(
    .AW(AW), .DW(DW), .CTRL_OFS(CTRL_OFS), .SCE_OFS(SCE_OFS), .FLAG_OFS(FLAG_OFS)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl_set(ctrl_set), .dev_set(dev_set), .rdata(cfg_rdata),
    .en_addr(en_addr), .en_cfg(en_cfg), .sce_addr(sce_addr), .sce_cfg(sce_cfg),
    .ctrl_irq(ctrl_irq), .dev_irq(dev_irq)
  );

  usb_ar_decide decide_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_code(req_code), .req_value(req_value), .state(state),
    .en_addr(en_addr), .en_cfg(en_cfg), .status_stb(status_stb), .zlp_ack(zlp_ack),
    .pend(pend), .zlp_req(zlp_req), .ctrl_set(ctrl_set)
  );

  usb_ar_state #(.DEV_AW(DEV_AW)) state_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pend(pend), .zlp_ack(zlp_ack),
    .sce_addr(sce_addr), .sce_cfg(sce_cfg), .state(state), .dev_addr(dev_addr),
    .dev_set(dev_set)
  );

  assign dev_state = state;

  // R5: firmware interrupt and automatic packet never come from the same status stage
  a_r5_irq_or_zlp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_irq) |-> !zlp_req);

endmodule

// File: tb/usb_ctl_autoresp_tb_top.sv
`timescale 1ns/1ps
module usb_ctl_autoresp_tb_top;

  localparam logic [7:0] OFS_CTRL = 8'h2C;
  localparam logic [7:0] OFS_SCE  = 8'h2E;
  localparam logic [7:0] OFS_FLAG = 8'h30;

  logic clk = 0, rst_n = 0, bus_reset = 0, req_valid = 0, status_stb = 0, zlp_ack = 0;
  logic cfg_wr = 0;
  logic [7:0]  req_code = 0, req_value = 0, cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic zlp_req, ctrl_irq, dev_irq;
  logic [1:0] dev_state;
  logic [6:0] dev_addr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  usb_ctl_autoresp dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_code(req_code), .req_value(req_value), .status_stb(status_stb),
    .zlp_ack(zlp_ack), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .zlp_req(zlp_req), .ctrl_irq(ctrl_irq), .dev_irq(dev_irq),
    .dev_state(dev_state), .dev_addr(dev_addr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    cfg_addr = a;
    #1;
    v = int'(cfg_rdata);
  endtask

  task automatic send_req(input logic [7:0] code, input logic [7:0] val);
    req_valid = 1; req_code = code; req_value = val;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic stat();
    status_stb = 1;
    @(negedge clk);
    status_stb = 0;
  endtask

  task automatic ack();
    zlp_ack = 1;
    @(negedge clk);
    zlp_ack = 0;
  endtask

  task automatic brst();
    bus_reset = 1;
    @(negedge clk);
    bus_reset = 0;
  endtask

  task automatic go_state(input int st);
    brst();
    if (st >= 1) begin send_req(8'd5, 8'd3); stat(); ack(); end
    if (st == 2) begin send_req(8'd9, 8'd1); stat(); ack(); end
    wr(OFS_FLAG, 16'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "dev_state", int'(dev_state), 0);
    chk("R1", "dev_addr", int'(dev_addr), 0);
    chk("R1", "zlp_req", int'(zlp_req), 0);
    chk("R1", "irqs", int'({dev_irq, ctrl_irq}), 0);
    rd(OFS_CTRL, v); chk("R1", "ctrl reg", v, 0);
    rd(OFS_SCE, v);  chk("R1", "sce reg", v, 0);
    rd(OFS_FLAG, v); chk("R1", "flag reg", v, 0);

    // R2 reserved bits
    wr(OFS_CTRL, 16'hFFFF); rd(OFS_CTRL, v); chk("R2", "ctrl all ones", v, 3);
    wr(OFS_CTRL, 16'hFFFC); rd(OFS_CTRL, v); chk("R2", "ctrl reserved only", v, 0);
    wr(OFS_SCE, 16'hFFFE);  rd(OFS_SCE, v);  chk("R2", "sce reserved", v, 2);

    // R9 write zero keeps flag; same-cycle set beats clear; write one clears
    wr(OFS_CTRL, 16'h0000);
    go_state(0);
    send_req(8'd5, 8'd4); stat();
    chk("R9", "ctrl_irq set", int'(ctrl_irq), 1);
    wr(OFS_FLAG, 16'h0000);
    chk("R9", "write zero keeps", int'(ctrl_irq), 1);
    rd(OFS_FLAG, v); chk("R9", "flag readback", v, 1);
    wr(OFS_FLAG, 16'h0001);
    chk("R9", "write one clears", int'(ctrl_irq), 0);
    send_req(8'd5, 8'd4);
    status_stb = 1; cfg_wr = 1; cfg_addr = OFS_FLAG; cfg_wdata = 16'h0001;
    @(negedge clk);
    status_stb = 0; cfg_wr = 0;
    chk("R9", "set wins over clear", int'(ctrl_irq), 1);
    wr(OFS_FLAG, 16'hFFFF);

    // R10 bus reset keeps registers
    wr(OFS_CTRL, 16'h0003); wr(OFS_SCE, 16'h0001);
    go_state(2);
    chk("R10", "reached configured", int'(dev_state), 2);
    brst();
    chk("R10", "state default", int'(dev_state), 0);
    chk("R10", "addr cleared", int'(dev_addr), 0);
    rd(OFS_CTRL, v); chk("R10", "ctrl kept", v, 3);
    rd(OFS_SCE, v);  chk("R10", "sce kept", v, 1);

    // sweep: enables x state-change enables x state x request kind x value
    for (int en = 0; en < 4; en++) begin
      for (int sce = 0; sce < 4; sce++) begin
        wr(OFS_CTRL, 16'(en)); wr(OFS_SCE, 16'(sce));
        for (int st = 0; st < 3; st++) begin
          for (int k = 0; k < 3; k++) begin
            for (int vi = 0; vi < 2; vi++) begin
              logic [7:0] code, val;
              bit qual, auto_on, isreq, chg, irq_en;
              int nst, pre_addr, exp_addr;
              string tag;
              code = (k == 0) ? 8'd5 : (k == 1) ? 8'd9 : 8'd6;
              val  = (vi == 0) ? 8'd0 : 8'd5;
              isreq = (k != 2);
              qual = (k == 0 && st == 0) ||
                     (k == 1 && ((st == 1 && val != 0) || (st == 2 && val == 0)));
              auto_on = qual && ((k == 0) ? en[0] : en[1]);
              nst = st; chg = 0;
              if (k == 0 && st == 0 && val != 0) begin nst = 1; chg = 1; end
              if (k == 1 && st == 1 && val != 0) begin nst = 2; chg = 1; end
              if (k == 1 && st == 2 && val == 0) begin nst = 1; chg = 1; end
              irq_en = (k == 0) ? sce[0] : sce[1];
              pre_addr = (st == 0) ? 0 : 3;
              exp_addr = (k == 0 && st == 0 && val != 0) ? 5 : pre_addr;
              tag = (k == 0) ? "R3" : (k == 1) ? "R4" : "R11";

              go_state(st);
              chk("R6", "start state", int'(dev_state), st);
              send_req(code, val);
              chk("R7", "addr held before ack", int'(dev_addr), pre_addr);
              stat();
              chk(tag, "zlp_req", int'(zlp_req), int'(isreq && auto_on));
              chk("R5", "ctrl_irq", int'(ctrl_irq), int'(isreq && !auto_on));
              @(negedge clk);
              chk("R3", "zlp pulse ends", int'(zlp_req), 0);
              ack();
              chk(k == 2 ? "R11" : "R6", "state after ack", int'(dev_state), nst);
              chk("R8", "dev_irq", int'(dev_irq), int'(chg && irq_en));
              chk("R7", "addr after ack", int'(dev_addr), exp_addr);
            end
          end
        end
      end
    end

    summary();
    $finish;
  end

endmodule